// File: doc/BRIEF.md
# Double-Buffered PWM Channel

This block is one 16-bit pulse-width modulation channel. It advances on a PWM clock enable that a prescaler outside the block produces. Software writes a period value and a high-time value into holding registers. The channel copies both values into working registers only at the end of a period, so a new setting never shortens or corrupts the period that is running. A free-running counter measures each period. A set/clear flip-flop makes the waveform, and a polarity bit fixes the idle level of the output.

Two settings hold the output at a steady level with no glitch. A width of zero keeps the output idle for the whole period (0% duty). A width equal to or larger than a nonzero period keeps the output active for the whole period (100% duty). A period value of zero selects 65536 ticks, so in that mode the widest pulse is 65535 ticks. Each period rollover sets a status flag. Software clears the flag by writing a one to it. An interrupt output follows the flag when its enable bit is set. Registers are reached through a plain write strobe, an address and a combinational read port.

Top module: `pwm_buffered_channel`

## Requirements
- R1: After reset every register reads zero and `pwm_out` is 0. The register addresses are: 0 control/status, 1 period holding register, 2 width holding register, 3 counter (read-only).
- R2: Reads of addresses 4 to 7 and of control bits 3 to 6 and 8 to 15 return zero. Writes to those locations, and writes to the counter at address 3, have no effect.
- R3: While the enable bit (control bit 0) is clear, the counter reads zero and `pwm_out` equals the polarity bit (control bit 1).
- R4: While the channel is enabled, the counter advances by one on each clock with `tick` high and holds otherwise. After reaching working period minus one it returns to zero. A working period of 0 gives 65536 ticks.
- R5: Values written to the period and width holding registers reach the working copies only at a counter rollover while the channel is enabled. While the channel is disabled, the working copies follow the holding registers.
- R6: When the channel is enabled, `pwm_out` is one clock behind the counter. It is the inverse of the polarity bit while the counter is below the working width, and equals the polarity bit otherwise.
- R7: A working width of 0 holds `pwm_out` at the polarity level for the whole period.
- R8: A working width greater than or equal to a nonzero working period holds `pwm_out` at the inverted polarity level for the whole period.
- R9: With a working period of 0 and a width of 65535, the output is active for 65535 ticks and idle for exactly one tick per period.
- R10: The flag (control bit 7) is set on each rollover and cleared by writing 1 to it. A set and a clear in the same clock leave it set. `irq` is high while the flag and the interrupt enable (control bit 2) are both set.
- R11: The counter keeps advancing and rolling over while the output is held at 0% or 100% duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | PWM clock enable from the prescaler |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| pwm_out | output | 1 | PWM waveform |
| irq | output | 1 | Rollover interrupt request |

## Verification
The hardest case to reach from the ports is the 65536-tick period paired with the 65535-tick width. Only this case shows the single idle tick, and it takes a full 16-bit count to get there. The bench programs the holding registers while the channel is disabled, so they pass straight into the working copies. It then drives `tick` high on every clock for just over one full period and compares the output and counter with the model on each cycle. Register writes that land in the same clock as a rollover are reached by changing the width and period while `tick` runs at one third of the clock rate. The bench also clears the flag at points that fall on and off the rollover edge.

// File: rtl/pwm_buffered_channel.sv
module pwm_buffered_channel #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              pwm_out,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_PER  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_WID  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(3);
  localparam logic [CNT_W-1:0]  ONE    = CNT_W'(1);

  logic             en_q, pol_q, ie_q, flag_q, state_q;
  logic [CNT_W-1:0] per_buf, wid_buf, per_act, wid_act, cnt_q;

  wire wr_ctrl = wr_en && (addr == A_CTRL);
  wire wrap    = en_q && tick && (cnt_q == per_act - ONE);
  wire zero_w  = (wid_act == '0);
  wire full_w  = (per_act != '0) && (wid_act >= per_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      pol_q   <= 1'b0;
      ie_q    <= 1'b0;
      per_buf <= '0;
      wid_buf <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= wdata[0];
        pol_q <= wdata[1];
        ie_q  <= wdata[2];
      end
      if (wr_en && addr == A_PER) per_buf <= wdata;
      if (wr_en && addr == A_WID) wid_buf <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_act <= '0;
      wid_act <= '0;
    end else if (!en_q || wrap) begin
      per_act <= per_buf;
      wid_act <= wid_buf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!en_q)    cnt_q <= '0;
    else if (wrap)     cnt_q <= '0;
    else if (tick)     cnt_q <= cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  state_q <= 1'b0;
    else if (!en_q || zero_w)    state_q <= 1'b0;
    else if (full_w)             state_q <= 1'b1;
    else if (cnt_q == '0)        state_q <= 1'b1;
    else if (cnt_q == wid_act)   state_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     flag_q <= 1'b0;
    else if (wrap)                  flag_q <= 1'b1;
    else if (wr_ctrl && wdata[7])   flag_q <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: begin
        rdata[0] = en_q;
        rdata[1] = pol_q;
        rdata[2] = ie_q;
        rdata[7] = flag_q;
      end
      A_PER:   rdata = per_buf;
      A_WID:   rdata = wid_buf;
      A_CNT:   rdata = cnt_q;
      default: rdata = '0;
    endcase
  end

  assign pwm_out = pol_q ^ state_q;
  assign irq     = flag_q & ie_q;
endmodule

module pwm_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             en_q,
  input logic             state_q,
  input logic             flag_q,
  input logic [CNT_W-1:0] per_act,
  input logic [CNT_W-1:0] wid_act,
  input logic [CNT_W-1:0] cnt_q
);
  a_r3_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (cnt_q == '0 && !state_q));

  a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !tick) |=> (cnt_q == $past(cnt_q)));

  a_r5_period_not_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (per_act != '0) |-> (cnt_q < per_act));

  a_r7_zero_width_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && wid_act == '0) |=> !state_q);

  a_r8_full_width_active: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && wid_act != '0 && per_act != '0 && wid_act >= per_act) |=> state_q);

  a_r10_flag_on_rollover: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(en_q && tick && (cnt_q == per_act - CNT_W'(1))));
endmodule

bind pwm_buffered_channel pwm_channel_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .en_q(en_q), .state_q(state_q),
  .flag_q(flag_q), .per_act(per_act), .wid_act(wid_act), .cnt_q(cnt_q)
);

// File: tb/pwm_buffered_channel_tb.sv
module pwm_buffered_channel_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic        pwm_out, irq;

  int    vectors = 0;
  int    fails = 0;
  string cur_req = "R1";

  pwm_buffered_channel dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  bit m_en, m_pol, m_ie, m_flag, m_state;
  int m_pbuf, m_wbuf, m_pact, m_wact, m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_pol = 0; m_ie = 0; m_flag = 0; m_state = 0;
      m_pbuf = 0; m_wbuf = 0; m_pact = 0; m_wact = 0; m_cnt = 0;
    end else begin
      int  plen;
      bit  roll, nstate;
      plen   = (m_pact == 0) ? 65536 : m_pact;
      roll   = m_en && tick && (m_cnt == plen - 1);
      nstate = m_en && (m_wact != 0) &&
               (((m_pact != 0) && (m_wact >= m_pact)) || (m_cnt < m_wact));
      if (!m_en || roll) begin m_pact = m_pbuf; m_wact = m_wbuf; end
      if (!m_en) m_cnt = 0;
      else if (tick) m_cnt = roll ? 0 : m_cnt + 1;
      m_state = nstate;
      if (roll) m_flag = 1;
      else if (wr_en && addr == 3'd0 && wdata[7]) m_flag = 0;
      if (wr_en) begin
        case (addr)
          3'd0: begin m_en = wdata[0]; m_pol = wdata[1]; m_ie = wdata[2]; end
          3'd1: m_pbuf = int'(wdata);
          3'd2: m_wbuf = int'(wdata);
          default: ;
        endcase
      end
    end
  end

  function automatic logic [15:0] exp_rd();
    case (addr)
      3'd0: exp_rd = {8'd0, m_flag, 4'd0, m_ie, m_pol, m_en};
      3'd1: exp_rd = 16'(m_pbuf);
      3'd2: exp_rd = 16'(m_wbuf);
      3'd3: exp_rd = 16'(m_cnt);
      default: exp_rd = 16'd0;
    endcase
  endfunction

  task automatic cyc();
    logic [15:0] er;
    logic eo, ei;
    @(negedge clk);
    er = exp_rd();
    eo = m_pol ^ m_state;
    ei = m_flag & m_ie;
    vectors++;
    if (rdata !== er || pwm_out !== eo || irq !== ei) begin
      fails++;
      $display("FAIL %s t=%0t addr=%0d actual rdata=%h out=%b irq=%b expected rdata=%h out=%b irq=%b",
               cur_req, $time, addr, rdata, pwm_out, irq, er, eo, ei);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic run(input int n, input int every, input logic [2:0] a);
    addr = a;
    for (int i = 0; i < n; i++) begin
      tick = (every != 0) && (i % every == 0);
      cyc();
    end
    tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired in phase %s", cur_req);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    // R1: reset values
    cur_req = "R1";
    cyc(); cyc();
    rst_n = 1'b1;
    for (int a = 0; a < 4; a++) begin addr = 3'(a); cyc(); end
    // R2: reserved addresses, unused bits, read-only counter
    cur_req = "R2";
    wr(3'd5, 16'hFFFF); run(2, 0, 3'd5);
    wr(3'd0, 16'hFF78); run(2, 0, 3'd0);
    wr(3'd3, 16'h1234); run(2, 0, 3'd3);
    // R6: basic waveform, period 10 width 4
    cur_req = "R6";
    wr(3'd1, 16'd10); wr(3'd2, 16'd4);
    wr(3'd0, 16'h0005);
    run(45, 1, 3'd3);
    // R10: flag clear and interrupt
    cur_req = "R10";
    wr(3'd0, 16'h0085); run(3, 1, 3'd0);
    for (int k = 0; k < 12; k++) begin tick = 1'b1; wr(3'd0, 16'h0085); end
    tick = 1'b0;
    run(25, 1, 3'd0);
    // R5: buffered updates under a slow tick
    cur_req = "R5";
    tick = 1'b1; wr(3'd2, 16'd7); tick = 1'b0;
    run(7, 3, 3'd3);
    wr(3'd1, 16'd12);
    run(60, 3, 3'd3);
    // R7: zero width with inverted polarity
    cur_req = "R7";
    wr(3'd0, 16'h0007); wr(3'd2, 16'd0);
    run(40, 1, 3'd3);
    // R8: width above and equal to period
    cur_req = "R8";
    wr(3'd2, 16'd20); run(30, 1, 3'd3);
    wr(3'd2, 16'd12); run(30, 2, 3'd3);
    // R11: counter runs while held
    cur_req = "R11";
    run(30, 1, 3'd3);
    // R3: disable
    cur_req = "R3";
    wr(3'd0, 16'h0002); run(12, 1, 3'd3);
    wr(3'd0, 16'h0000); run(4, 1, 3'd0);
    // R4: period of one tick
    cur_req = "R4";
    wr(3'd1, 16'd1); wr(3'd2, 16'd1); run(2, 0, 3'd3);
    wr(3'd0, 16'h0001); run(10, 1, 3'd3);
    wr(3'd0, 16'h0000); run(2, 1, 3'd3);
    // R9: 65536-tick period with widest pulse
    cur_req = "R9";
    wr(3'd1, 16'd0); wr(3'd2, 16'd65535); run(2, 0, 3'd3);
    wr(3'd0, 16'h0005);
    run(65545, 1, 3'd3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule